// File: doc/BRIEF.md
# Board Interrupt Distribution Router

This block spreads the level-sensitive interrupt lines of a board across two layers of interrupt control. Every board line is copied to the same-numbered input of each of four secondary board-level interrupt controllers. A sparse subset of the low board lines is also sent straight to the external inputs of the interrupt controller that sits beside the processor cluster. The output of each secondary controller comes back into the router and is placed on its own line of the processor-side vector.

Levels are passed through unchanged, so a line stays asserted for as long as its source holds it. Following the FPGA register-at-the-boundary convention, all outputs go through one register stage. This stage has a synchronous active-high reset. Only one routing arrangement is built. The secondary controllers and the processor-side controller lie outside this block.

Top module: `irq_route_fabric`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `sec_in_o` and `cpu_irq_o` are all zero after that edge.
- R2: Outside reset, every bit `sec_in_o[n*64+i]` (controller n = 0..3, board line i = 0..63) equals the `board_irq_i[i]` sampled at the previous rising edge.
- R3: Processor-side lines follow these board lines, written board line→processor line: 19→0, 4→1, 5→2, 29→3, 12→4, 13→5, 10→6, 20→7, 21→8, 28→9, 17→14, 18→15.
- R4: Board lines 32 to 63 have no effect on `cpu_irq_o`.
- R5: Board lines below 32 that are not listed in R3 have no effect on `cpu_irq_o`.
- R6: Processor line 10+n follows `sec_irq_i[n]` for n = 0..3.
- R7: Processor lines 16 to 31 stay low at all times.
- R8: Each output takes the new input level at the first rising edge after the input changes, and not before. Rising and falling levels are both carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_irq_i | input | 64 | Board interrupt levels, bit i is board line i |
| sec_irq_i | input | 4 | Outputs of the four secondary controllers, bit n from controller n |
| sec_in_o | output | 256 | Inputs to the secondary controllers, bits [n*64 +: 64] feed controller n |
| cpu_irq_o | output | 32 | External interrupt inputs of the processor-side controller |

## Verification
The bench uses the default sizes: 64 board lines, four secondary controllers and a 32-line processor vector. At these sizes the whole input space can be walked one line at a time. Walking a single asserted line across all 64 board inputs and all four controller outputs, and then a single cleared line across an all-ones background, shows every map entry, every unmapped line and every upper line in isolation. Random dense patterns and a check taken before the clock edge then cover line overlap and the one-cycle latency.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Direct board-to-processor remap: returns the processor line for a board
  // line, or -1 when the board line has no direct processor destination.
  function automatic int direct_line(input int board);
    case (board)
      4:  return 1;
      5:  return 2;
      10: return 6;
      12: return 4;
      13: return 5;
      17: return 14;
      18: return 15;
      19: return 0;
      20: return 7;
      21: return 8;
      28: return 9;
      29: return 3;
      default: return -1;
    endcase
  endfunction

  // True when some source (direct map or secondary return) drives line j.
  function automatic bit line_driven(input int j, input int n_direct,
                                     input int n_sec, input int sec_line0);
    for (int i = 0; i < n_direct; i++)
      if (direct_line(i) == j) return 1'b1;
    return (j >= sec_line0) && (j < sec_line0 + n_sec);
  endfunction

endpackage

// File: rtl/irq_fanout.sv
module irq_fanout #(
  parameter int N_BOARD = 64,
  parameter int N_SEC   = 4,
  localparam int W_OUT  = N_BOARD * N_SEC
) (
  input  logic [N_BOARD-1:0] board_irq,
  output logic [W_OUT-1:0]   fan_out
);

  for (genvar n = 0; n < N_SEC; n++) begin : g_ctrl
    assign fan_out[n*N_BOARD +: N_BOARD] = board_irq;
  end

endmodule

// File: rtl/irq_cpu_map.sv
module irq_cpu_map
  import irq_route_pkg::*;
#(
  parameter int N_DIRECT  = 32,
  parameter int N_SEC     = 4,
  parameter int N_CPU     = 32,
  parameter int SEC_LINE0 = 10
) (
  input  logic [N_DIRECT-1:0] low_irq,
  input  logic [N_SEC-1:0]    sec_irq,
  output logic [N_CPU-1:0]    cpu_irq
);

  always_comb begin
    cpu_irq = '0;
    for (int i = 0; i < N_DIRECT; i++) begin
      if (direct_line(i) >= 0 && direct_line(i) < N_CPU)
        cpu_irq[direct_line(i)] = cpu_irq[direct_line(i)] | low_irq[i];
    end
    for (int n = 0; n < N_SEC; n++) begin
      if (SEC_LINE0 + n < N_CPU)
        cpu_irq[SEC_LINE0 + n] = cpu_irq[SEC_LINE0 + n] | sec_irq[n];
    end
  end

endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric #(
  parameter int N_BOARD   = 64,
  parameter int N_SEC     = 4,
  parameter int N_CPU     = 32,
  parameter int N_DIRECT  = 32,
  parameter int SEC_LINE0 = 10,
  localparam int W_SEC    = N_BOARD * N_SEC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_BOARD-1:0] board_irq_i,
  input  logic [N_SEC-1:0]   sec_irq_i,
  output logic [W_SEC-1:0]   sec_in_o,
  output logic [N_CPU-1:0]   cpu_irq_o
);

  logic [W_SEC-1:0] fan_d;
  logic [N_CPU-1:0] cpu_d;

  irq_fanout #(.N_BOARD(N_BOARD), .N_SEC(N_SEC)) u_fanout (
    .board_irq (board_irq_i),
    .fan_out   (fan_d)
  );

  irq_cpu_map #(
    .N_DIRECT (N_DIRECT), .N_SEC(N_SEC), .N_CPU(N_CPU), .SEC_LINE0(SEC_LINE0)
  ) u_cpu_map (
    .low_irq (board_irq_i[N_DIRECT-1:0]),
    .sec_irq (sec_irq_i),
    .cpu_irq (cpu_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_in_o  <= '0;
      cpu_irq_o <= '0;
    end else begin
      sec_in_o  <= fan_d;
      cpu_irq_o <= cpu_d;
    end
  end

endmodule

// File: rtl/irq_route_fabric_chk.sv
module irq_route_fabric_chk
  import irq_route_pkg::*;
#(
  parameter int N_BOARD   = 64,
  parameter int N_SEC     = 4,
  parameter int N_CPU     = 32,
  parameter int N_DIRECT  = 32,
  parameter int SEC_LINE0 = 10
) (
  input logic                     clk,
  input logic                     rst,
  input logic [N_BOARD-1:0]       board_irq_i,
  input logic [N_SEC-1:0]         sec_irq_i,
  input logic [N_BOARD*N_SEC-1:0] sec_in_o,
  input logic [N_CPU-1:0]         cpu_irq_o
);

  logic seen_rst = 1'b0;
  logic live     = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    live <= seen_rst & ~rst;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sec_in_o == '0 && cpu_irq_o == '0));

  p_broadcast_r2: assert property (@(posedge clk) disable iff (rst)
    live |-> (sec_in_o == {N_SEC{$past(board_irq_i)}}));

  for (genvar i = 0; i < N_DIRECT; i++) begin : g_direct
    if (direct_line(i) >= 0 && direct_line(i) < N_CPU) begin : g_on
      p_direct_map_r3: assert property (@(posedge clk) disable iff (rst)
        live |-> (cpu_irq_o[direct_line(i)] == $past(board_irq_i[i])));
    end
  end

  for (genvar n = 0; n < N_SEC; n++) begin : g_sec
    if (SEC_LINE0 + n < N_CPU) begin : g_on
      p_sec_return_r6: assert property (@(posedge clk) disable iff (rst)
        live |-> (cpu_irq_o[SEC_LINE0 + n] == $past(sec_irq_i[n])));
    end
  end

  for (genvar j = 0; j < N_CPU; j++) begin : g_idle
    if (!line_driven(j, N_DIRECT, N_SEC, SEC_LINE0)) begin : g_on
      p_tied_low_r7: assert property (@(posedge clk) disable iff (rst)
        live |-> !cpu_irq_o[j]);
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (live && $stable(board_irq_i) && $stable(sec_irq_i)) |=>
      ($stable(sec_in_o) && $stable(cpu_irq_o)));

endmodule

bind irq_route_fabric irq_route_fabric_chk #(
  .N_BOARD(N_BOARD), .N_SEC(N_SEC), .N_CPU(N_CPU),
  .N_DIRECT(N_DIRECT), .SEC_LINE0(SEC_LINE0)
) u_chk (
  .clk(clk), .rst(rst), .board_irq_i(board_irq_i), .sec_irq_i(sec_irq_i),
  .sec_in_o(sec_in_o), .cpu_irq_o(cpu_irq_o)
);

// File: tb/irq_route_fabric_test.sv
module irq_route_fabric_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  board = '0;
  logic [3:0]   sec = '0;
  logic [255:0] sec_in;
  logic [31:0]  cpu;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_route_fabric uut (
    .clk(clk), .rst(rst), .board_irq_i(board), .sec_irq_i(sec),
    .sec_in_o(sec_in), .cpu_irq_o(cpu)
  );

  // Expected processor vector, built per processor line from the requirements.
  function automatic logic [31:0] exp_cpu(input logic [63:0] b, input logic [3:0] s);
    logic [31:0] e = '0;
    e[0]  = b[19]; e[1]  = b[4];  e[2]  = b[5];  e[3]  = b[29];
    e[4]  = b[12]; e[5]  = b[13]; e[6]  = b[10]; e[7]  = b[20];
    e[8]  = b[21]; e[9]  = b[28]; e[14] = b[17]; e[15] = b[18];
    e[13:10] = s;
    return e;
  endfunction

  task automatic check_vec(input string req, input logic [255:0] act_s,
                           input logic [31:0] act_c, input logic [255:0] exp_s,
                           input logic [31:0] exp_c);
    tests++;
    if (act_s !== exp_s || act_c !== exp_c) begin
      fails++;
      $display("FAIL %s: sec_in=%h cpu=%h expected sec_in=%h cpu=%h",
               req, act_s, act_c, exp_s, exp_c);
    end
  endtask

  // Drive on falling edge, capture at rising edge, sample at next falling edge.
  task automatic apply(input logic [63:0] b, input logic [3:0] s, input string req);
    board = b; sec = s;
    @(posedge clk); @(negedge clk);
    check_vec(req, sec_in, cpu, {4{b}}, exp_cpu(b, s));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    board = '1; sec = '1;
    @(negedge clk); @(negedge clk);
    // R1: reset clears outputs even with all inputs high
    check_vec("R1 reset", sec_in, cpu, '0, '0);
    rst = 1'b0;
    board = '0; sec = '0;
    @(negedge clk);

    // Walk one high board line: R2 broadcast, R3 map, R4 upper, R5 unmapped, R7 idle
    for (int i = 0; i < 64; i++)
      apply(64'd1 << i, 4'd0,
            i >= 32 ? "R4 upper line" :
            (exp_cpu(64'd1 << i, 4'd0) != 0 ? "R3 direct map" : "R5 unmapped"));
    // Walk one low line over an all-ones background
    for (int i = 0; i < 64; i++)
      apply(~(64'd1 << i), 4'hF, i >= 32 ? "R4 upper clear" : "R2/R3 clear");
    // R6: each secondary return alone
    for (int n = 0; n < 4; n++)
      apply('0, 4'd1 << n, "R6 secondary return");
    // R7: all inputs high leaves lines 16..31 low
    apply('1, 4'hF, "R7 idle lines");
    tests++;
    if (cpu[31:16] !== 16'h0) begin
      fails++;
      $display("FAIL R7: cpu[31:16]=%h expected 0000", cpu[31:16]);
    end
    // R8: change must not appear before the edge; falling level then carried
    board = '0; sec = '0;
    #2;
    tests++;
    if (cpu !== exp_cpu('1, 4'hF) || sec_in !== '1) begin
      fails++;
      $display("FAIL R8 early change: cpu=%h expected %h", cpu, exp_cpu('1, 4'hF));
    end
    @(posedge clk); @(negedge clk);
    check_vec("R8 falling level", sec_in, cpu, '0, '0);
    // Random dense patterns
    for (int k = 0; k < 200; k++)
      apply({$urandom, $urandom}, 4'($urandom), "R2/R3/R6 random");
    // R1 again mid-run
    rst = 1'b1;
    board = '1; sec = '1;
    @(posedge clk); @(negedge clk);
    check_vec("R1 reset mid-run", sec_in, cpu, '0, '0);
    rst = 1'b0;
    apply(64'h1234_5678_9ABC_DEF0, 4'hA, "R2 after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule